// File: doc/BRIEF.md
# Store-Miss Write Buffer with Line Hazard Stall

This block sits beside a read-allocate data cache. Stores that miss in the cache do not allocate a line. Instead they go into a small in-order queue. The queue holds the address, the data and the byte enables of each store, and it writes them to memory one at a time through a valid/ready port. Cache hits to other lines continue while stores are still queued.

The load side gives the cache-line address of a pending load. If any queued store targets that same line, the block raises a stall flag. The flag stays high until that store, and every other queued store to the same line, has completed its memory write. The load is not held until the whole queue is empty. This block does not merge stores and does not forward store data to loads.

Top module: `wbuf_hazard`

## Requirements
- R1: After reset the queue is empty: `mem_valid` is 0, `st_ready` is 1 and `ld_stall` is 0.
- R2: A store is accepted in any cycle where `st_valid` and `st_ready` are both 1. If the queue was empty, the store appears on `mem_addr`/`mem_data`/`mem_be` with `mem_valid`=1 in the next cycle.
- R3: Stores leave on the memory port in the same order they were accepted. While `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_data` and `mem_be` do not change.
- R4: An entry is removed in the cycle its handshake completes (`mem_valid` and `mem_ready` both 1). From the next cycle, that entry no longer shows on the memory port and no longer affects `ld_stall`.
- R5: The queue holds DEPTH (default 4) entries. When it is full, `st_ready` is 0. A store offered while the queue is full is not taken, and it never appears on the memory port.
- R6: `ld_stall` is 1 when `ld_valid` is 1 and `ld_line` equals address bits [31:5] of any queued store.
- R7: `ld_stall` is 0 when `ld_valid` is 0, or when no queued store lies in line `ld_line`.
- R8: Once a stall is raised, it drops in the cycle after the last queued store to that line commits, even if stores to other lines are still queued.
- R9: A store offered in a cycle affects `ld_stall` only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store miss offered |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Queue can accept a store |
| ld_valid | input | 1 | Load line check requested |
| ld_line | input | 27 | Load cache-line address (address bits 31:5) |
| ld_stall | output | 1 | Load must wait |
| mem_valid | output | 1 | Head entry is being written |
| mem_addr | output | 32 | Head entry address |
| mem_data | output | 32 | Head entry data |
| mem_be | output | 4 | Head entry byte enables |
| mem_ready | input | 1 | Memory accepts the head entry |

## Verification
`st_ready`, `ld_stall` and the memory port are all combinational views of the registered queue. Each result is therefore due in the same cycle as a load probe, and one clock edge after a store acceptance or a commit.

The bench drives inputs at the falling edge and samples 1 ns later, so it sees the state that the previous rising edge produced. After every single store and after every single commit, it probes a fixed set of lines. This puts each release check exactly one edge after the matching handshake.

// File: rtl/wbuf_hazard.sv
module wbuf_hazard #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [AW-1:0]         st_addr,
  input  logic [DW-1:0]         st_data,
  input  logic [DW/8-1:0]       st_be,
  output logic                  st_ready,
  input  logic                  ld_valid,
  input  logic [AW-$clog2(LINE_BYTES)-1:0] ld_line,
  output logic                  ld_stall,
  output logic                  mem_valid,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_data,
  output logic [DW/8-1:0]       mem_be,
  input  logic                  mem_ready
);
  localparam int BW  = DW / 8;
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [AW-1:0]    q_addr [DEPTH];
  logic [DW-1:0]    q_data [DEPTH];
  logic [BW-1:0]    q_be   [DEPTH];
  logic [DEPTH-1:0] q_vld, hit;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  wire enq = st_valid & st_ready;
  wire deq = mem_valid & mem_ready;

  assign st_ready  = (count != FULLC);
  assign mem_valid = q_vld[rd_ptr];
  assign mem_addr  = q_addr[rd_ptr];
  assign mem_data  = q_data[rd_ptr];
  assign mem_be    = q_be[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (enq) begin
        q_vld[wr_ptr] <= 1'b1;
        wr_ptr <= (wr_ptr == LASTP) ? '0 : wr_ptr + 1'b1;
      end
      if (deq) begin
        q_vld[rd_ptr] <= 1'b0;
        rd_ptr <= (rd_ptr == LASTP) ? '0 : rd_ptr + 1'b1;
      end
      count <= count + CW'(enq) - CW'(deq);
    end
  end

  always_ff @(posedge clk) begin
    if (enq) begin
      q_addr[wr_ptr] <= st_addr;
      q_data[wr_ptr] <= st_data;
      q_be[wr_ptr]   <= st_be;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = q_vld[i] && (q_addr[i][AW-1:OFS] == ld_line);
  end

  assign ld_stall = ld_valid && (|hit);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);

  a_r3_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_data) && $stable(mem_be)));

  a_r2_first_out: assert property (@(posedge clk) disable iff (!rst_n)
    (enq && !mem_valid) |=> (mem_valid && mem_addr == $past(st_addr) &&
                             mem_data == $past(st_data)));

  a_r7_empty_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !ld_stall);

  a_r4_last_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (deq && !enq && count == CW'(1)) |=> !mem_valid);
endmodule

// File: tb/wbuf_hazard_tb.sv
`timescale 1ns/1ps
module wbuf_hazard_tb;
  logic clk = 0, rst_n = 0;
  logic st_valid = 0, ld_valid = 0, mem_ready = 0;
  logic [31:0] st_addr = 0, st_data = 0;
  logic [3:0]  st_be = 0;
  logic [26:0] ld_line = 0;
  logic st_ready, ld_stall, mem_valid;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_be;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_addr [$];
  logic [31:0] m_data [$];
  logic [3:0]  m_be   [$];

  always #4 clk = ~clk;

  wbuf_hazard u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] addr_of(input int line, input int k);
    return 32'h4000_0000 + 32'(line) * 32 + 32'((k * 4) % 32);
  endfunction

  task automatic probe_all();
    for (int ln = 0; ln < 6; ln++) begin
      logic e;
      ld_line = addr_of(ln, 0) >> 5;
      ld_valid = 0; #1;
      chk("R7 idle", {31'd0, ld_stall}, 0);
      ld_valid = 1; #1;
      e = 0;
      foreach (m_addr[j]) if (m_addr[j][31:5] == ld_line) e = 1;
      chk("R6/R7/R8 stall", {31'd0, ld_stall}, {31'd0, e});
      ld_valid = 0;
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    logic exp_rdy;
    st_valid = 1; st_addr = a; st_data = d; st_be = b;
    exp_rdy = (m_addr.size() < 4);
    #1 chk("R5 ready", {31'd0, st_ready}, {31'd0, exp_rdy});
    ld_valid = 1; ld_line = a[31:5]; #1;
    begin
      logic e = 0;
      foreach (m_addr[j]) if (m_addr[j][31:5] == a[31:5]) e = 1;
      chk("R9 same-cycle", {31'd0, ld_stall}, {31'd0, e});
    end
    ld_valid = 0;
    if (exp_rdy) begin m_addr.push_back(a); m_data.push_back(d); m_be.push_back(b); end
    edge_step();
    st_valid = 0;
    #1 chk("R2 valid", {31'd0, mem_valid}, {31'd0, m_addr.size() > 0});
    if (m_addr.size() > 0) chk("R2/R3 head", mem_addr, m_addr[0]);
  endtask

  task automatic commit();
    logic [31:0] ha;
    #1 chk("R4 valid", {31'd0, mem_valid}, {31'd0, m_addr.size() > 0});
    if (m_addr.size() > 0) begin
      ha = mem_addr;
      edge_step(); #1;
      chk("R3 hold", mem_addr, ha);
      chk("R3 order addr", mem_addr, m_addr[0]);
      chk("R3 order data", mem_data, m_data[0]);
      chk("R3 order be", {28'd0, mem_be}, {28'd0, m_be[0]});
      mem_ready = 1;
      edge_step();
      mem_ready = 0;
      void'(m_addr.pop_front()); void'(m_data.pop_front()); void'(m_be.pop_front());
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 mem_valid", {31'd0, mem_valid}, 0);
    chk("R1 st_ready", {31'd0, st_ready}, 1);
    ld_valid = 1; ld_line = 0; #1;
    chk("R1 ld_stall", {31'd0, ld_stall}, 0);
    ld_valid = 0;
    @(negedge clk);
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 5; i++) begin
        int ln = (r == 2) ? (i % 2) : (r == 3 ? 5 - i : (i + r) % 6);
        store(addr_of(ln, i + r), 32'hA000_0000 + 32'(r * 16 + i), 4'(1 << ((i + r) % 4)) | 4'(r));
        probe_all();
      end
      for (int i = 0; i < 5; i++) begin
        commit();
        probe_all();
      end
      #1 chk("R4 empty", {31'd0, mem_valid}, 0);
      @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule